// File: doc/BRIEF.md
# Message-Signalled Interrupt Ring Writer

This block takes message-signalled interrupt writes arriving on a simple valid/ready inbound port, each carrying a 32-bit data word, and turns every accepted message into one 16-byte record written into a circular buffer that lives in system memory. The record is issued through a single-request memory write master with a request/acknowledge pair. A level interrupt tells the host that unread records are waiting.

Software sets the block up through a small word-indexed register port. It writes the buffer's 64-bit base address, chooses one of four ring sizes (32 KB to 256 KB) and sets the enable, full-detection, stop-on-full and interrupt-enable flags. It then drains records by advancing the read offset. The write offset is owned by the hardware and can only be read. When the ring fills, the block either back-pressures new messages or lets them overwrite unread records, depending on the flags.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_out` and `mem_req` are low and `msg_ready` is high.
- R2: The register indices are control 0, base upper word 3, base lower word 4, read offset 5 and write offset 6. Control keeps only bit 0 (enable), bit 1 (full detection), bit 3 (interrupt enable), bit 4 (stop-on-full) and bits 9:8 (size select), and its other bits read zero. Indices 1, 2 and 7 read zero and ignore writes. A software write to index 6 has no effect.
- R3: With enable set, an accepted message starts one memory write in the next cycle. The address is base + write offset. `mem_wdata` bits 31:0 hold the data word in little-endian byte order (data bits 7:0 in byte lane 0), and bits 127:32 are zero. `mem_req` and `mem_addr` hold steady until the cycle in which `mem_ack` is high.
- R4: The acknowledge advances the write offset by 16, modulo the ring size, and the offset stays 16-byte aligned. The ring size is 2^(15+s) bytes, where s is control bits 9:8.
- R5: Offsets are masked with (size − 1) & ~0xF. This applies to software writes of the read offset and to readback of both offsets under the current size.
- R6: The ring is full when (write offset + 16) mod size equals the read offset. While enable, full detection and stop-on-full are all set and the ring is full, `msg_ready` stays low and no memory write starts.
- R7: When the ring is full and stop-on-full or full detection is clear, a message is still written, and the write offset advances onto the read offset.
- R8: `irq_out` is high exactly when interrupt enable is set and the write offset differs from the read offset. A software write of the read offset equal to the write offset lowers it.
- R9: While enable is clear, an idle block keeps `msg_ready` high and drops messages: no memory write starts and the write offset is unchanged.
- R10: `msg_ready` is low while a memory write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| msg_valid | input | 1 | Inbound message present |
| msg_ready | output | 1 | Inbound message can be taken |
| msg_data | input | 32 | Inbound message data word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory byte address of the record |
| mem_wdata | output | 128 | Record contents |
| mem_ack | input | 1 | Memory write completion |
| irq_out | output | 1 | Host interrupt level |

## Verification
The hardest states to reach are a full ring and the wrap of the write offset. Filling even the smallest ring from the inbound port takes 2047 messages. The stimulus reaches a full ring at once by writing the read offset one record ahead of the write offset, so that the next step would land on it. From there it checks the stall and, with the stop flag cleared, the overwrite. The wrap is reached by one long run of messages on the 32 KB ring, with random acknowledge delays. Random size changes between bursts also check that the masks are reapplied to offsets that were stored under another size.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

   localparam int IDX_W = 3;

   localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd0;
   localparam logic [IDX_W-1:0] IDX_BASE_HI = 3'd3;
   localparam logic [IDX_W-1:0] IDX_BASE_LO = 3'd4;
   localparam logic [IDX_W-1:0] IDX_RD_OFF  = 3'd5;
   localparam logic [IDX_W-1:0] IDX_WR_OFF  = 3'd6;

   localparam int BIT_EN       = 0;
   localparam int BIT_FULL_DET = 1;
   localparam int BIT_IRQ_EN   = 3;
   localparam int BIT_STOP     = 4;
   localparam int BIT_SIZE_LO  = 8;

   localparam int SIZE_SEL_W = 2;
   localparam int NUM_SIZES  = 1 << SIZE_SEL_W;

   typedef struct packed {
      logic [SIZE_SEL_W-1:0] size_sel;
      logic                  stop_on_full;
      logic                  irq_en;
      logic                  full_det;
      logic                  enable;
   } ring_ctrl_t;

   typedef enum logic {WR_IDLE = 1'b0, WR_BUSY = 1'b1} wr_state_e;

   function automatic logic [31:0] ctrl_to_word(input ring_ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[BIT_EN]       = c.enable;
      w[BIT_FULL_DET] = c.full_det;
      w[BIT_IRQ_EN]   = c.irq_en;
      w[BIT_STOP]     = c.stop_on_full;
      w[BIT_SIZE_LO +: SIZE_SEL_W] = c.size_sel;
      return w;
   endfunction

   function automatic ring_ctrl_t word_to_ctrl(input logic [31:0] w);
      ring_ctrl_t c;
      c.enable       = w[BIT_EN];
      c.full_det     = w[BIT_FULL_DET];
      c.irq_en       = w[BIT_IRQ_EN];
      c.stop_on_full = w[BIT_STOP];
      c.size_sel     = w[BIT_SIZE_LO +: SIZE_SEL_W];
      return c;
   endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
   import msi_ring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [31:0]       reg_wdata,
   input  logic [OFF_W-1:0]  off_mask,
   input  logic [OFF_W-1:0]  roff_eff,
   input  logic [OFF_W-1:0]  woff_eff,
   output ring_ctrl_t        ctrl,
   output logic [ADDR_W-1:0] base,
   output logic [OFF_W-1:0]  roff_q,
   output logic [31:0]       reg_rdata
);

   localparam int HI_W = ADDR_W - 32;

   logic [HI_W-1:0] base_hi_q;
   logic [31:0]     base_lo_q;
   ring_ctrl_t      ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         base_hi_q <= '0;
         base_lo_q <= '0;
         roff_q    <= '0;
      end else if (reg_we) begin
         unique case (reg_idx)
            IDX_CTRL:    ctrl_q    <= word_to_ctrl(reg_wdata);
            IDX_BASE_HI: base_hi_q <= reg_wdata[HI_W-1:0];
            IDX_BASE_LO: base_lo_q <= reg_wdata;
            IDX_RD_OFF:  roff_q    <= reg_wdata[OFF_W-1:0] & off_mask;
            default:     ;
         endcase
      end
   end

   assign ctrl = ctrl_q;
   assign base = {base_hi_q, base_lo_q};

   always_comb begin
      unique case (reg_idx)
         IDX_CTRL:    reg_rdata = ctrl_to_word(ctrl_q);
         IDX_BASE_HI: reg_rdata = 32'(base_hi_q);
         IDX_BASE_LO: reg_rdata = base_lo_q;
         IDX_RD_OFF:  reg_rdata = 32'(roff_eff);
         IDX_WR_OFF:  reg_rdata = 32'(woff_eff);
         default:     reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
   import msi_ring_pkg::*;
#(
   parameter int OFF_W     = 18,
   parameter int MIN_SHIFT = 15,
   parameter int REC_BYTES = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SIZE_SEL_W-1:0] size_sel,
   input  logic [OFF_W-1:0]      roff_raw,
   input  logic                  advance,
   output logic [OFF_W-1:0]      off_mask,
   output logic [OFF_W-1:0]      woff_eff,
   output logic [OFF_W-1:0]      roff_eff,
   output logic                  full,
   output logic                  nonempty
);

   localparam logic [OFF_W-1:0] REC_STEP  = OFF_W'(REC_BYTES);
   localparam logic [OFF_W-1:0] ALIGN_CLR = ~OFF_W'(REC_BYTES - 1);

   logic [OFF_W-1:0] mask_tbl [NUM_SIZES];
   logic [OFF_W-1:0] woff_q;
   logic [OFF_W-1:0] woff_next;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_mask
      localparam logic [63:0] SPAN = (64'd1 << (MIN_SHIFT + s)) - 64'd1;
      assign mask_tbl[s] = OFF_W'(SPAN) & ALIGN_CLR;
   end

   assign off_mask  = mask_tbl[size_sel];
   assign woff_eff  = woff_q & off_mask;
   assign roff_eff  = roff_raw & off_mask;
   assign woff_next = (woff_eff + REC_STEP) & off_mask;
   assign full      = (woff_next == roff_eff);
   assign nonempty  = (woff_eff != roff_eff);

   always_ff @(posedge clk) begin
      if (!rst_n)       woff_q <= '0;
      else if (advance) woff_q <= woff_next;
   end

endmodule

// File: rtl/msi_ring_wr.sv
module msi_ring_wr
   import msi_ring_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int DATA_W        = 32,
   parameter int OFF_W         = 18,
   parameter int REC_BYTES     = 16,
   parameter bit LITTLE_ENDIAN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enable,
   input  logic                   stall,
   input  logic                   msg_valid,
   input  logic [DATA_W-1:0]      msg_data,
   output logic                   msg_ready,
   input  logic [ADDR_W-1:0]      base,
   input  logic [OFF_W-1:0]       woff_eff,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [REC_BYTES*8-1:0] mem_wdata,
   input  logic                   mem_ack,
   output logic                   advance,
   output logic                   busy
);

   localparam int WORD_BYTES = DATA_W / 8;

   wr_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   assign msg_ready = (state_q == WR_IDLE) && !stall;
   assign take      = msg_valid && msg_ready && enable;
   assign busy      = (state_q == WR_BUSY);
   assign mem_req   = busy;
   assign advance   = busy && mem_ack;
   assign mem_addr  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WR_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            WR_IDLE: if (take) begin
               state_q <= WR_BUSY;
               addr_q  <= base + ADDR_W'(woff_eff);
               data_q  <= msg_data;
            end
            WR_BUSY: if (mem_ack) state_q <= WR_IDLE;
            default: state_q <= WR_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < REC_BYTES; b++) begin : g_lane
      if (b < WORD_BYTES) begin : g_word
         if (LITTLE_ENDIAN) begin : g_le
            assign mem_wdata[b*8 +: 8] = data_q[b*8 +: 8];
         end else begin : g_be
            assign mem_wdata[b*8 +: 8] = data_q[(WORD_BYTES-1-b)*8 +: 8];
         end
      end else begin : g_pad
         assign mem_wdata[b*8 +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
   import msi_ring_pkg::*;
#(
   parameter int ADDR_W        = 64,
   parameter int DATA_W        = 32,
   parameter int REC_BYTES     = 16,
   parameter int MIN_SHIFT     = 15,
   parameter bit LITTLE_ENDIAN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [IDX_W-1:0]       reg_idx,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic                   msg_valid,
   output logic                   msg_ready,
   input  logic [DATA_W-1:0]      msg_data,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [REC_BYTES*8-1:0] mem_wdata,
   input  logic                   mem_ack,
   output logic                   irq_out
);

   localparam int OFF_W = MIN_SHIFT + NUM_SIZES - 1;

   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must lie in 33..64");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (REC_BYTES < DATA_W / 8 || (REC_BYTES & (REC_BYTES - 1)) != 0) begin : g_bad_rec
      $error("REC_BYTES must be a power of two holding the data word");
   end
   if (OFF_W > 32 || (1 << MIN_SHIFT) <= 2 * REC_BYTES) begin : g_bad_shift
      $error("MIN_SHIFT out of range");
   end

   ring_ctrl_t        ctrl_s;
   logic [ADDR_W-1:0] base_s;
   logic [OFF_W-1:0]  roff_q;
   logic [OFF_W-1:0]  off_mask;
   logic [OFF_W-1:0]  woff_eff;
   logic [OFF_W-1:0]  roff_eff;
   logic              full_s;
   logic              nonempty_s;
   logic              advance_s;
   logic              busy_s;
   logic              stall_s;

   msi_ring_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .off_mask  (off_mask),
      .roff_eff  (roff_eff),
      .woff_eff  (woff_eff),
      .ctrl      (ctrl_s),
      .base      (base_s),
      .roff_q    (roff_q),
      .reg_rdata (reg_rdata)
   );

   msi_ring_ptr #(.OFF_W(OFF_W), .MIN_SHIFT(MIN_SHIFT), .REC_BYTES(REC_BYTES)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_sel (ctrl_s.size_sel),
      .roff_raw (roff_q),
      .advance  (advance_s),
      .off_mask (off_mask),
      .woff_eff (woff_eff),
      .roff_eff (roff_eff),
      .full     (full_s),
      .nonempty (nonempty_s)
   );

   assign stall_s = ctrl_s.enable && ctrl_s.full_det && ctrl_s.stop_on_full && full_s;

   msi_ring_wr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
      .REC_BYTES(REC_BYTES), .LITTLE_ENDIAN(LITTLE_ENDIAN)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (ctrl_s.enable),
      .stall     (stall_s),
      .msg_valid (msg_valid),
      .msg_data  (msg_data),
      .msg_ready (msg_ready),
      .base      (base_s),
      .woff_eff  (woff_eff),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .advance   (advance_s),
      .busy      (busy_s)
   );

   assign irq_out = ctrl_s.irq_en && nonempty_s;

endmodule

// File: rtl/msi_ring_ctrl_chk.sv
module msi_ring_ctrl_chk #(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              full_det,
   input logic              stop_on_full,
   input logic              irq_en,
   input logic              full,
   input logic              busy,
   input logic              msg_ready,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [OFF_W-1:0]  woff_eff,
   input logic              irq_out
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3

   AST_WOFF_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mem_ack) |=> ((woff_eff == $past(woff_eff)) || $changed(woff_eff) && !$past(mem_req))); // R4

   AST_WOFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      woff_eff[3:0] == 4'h0); // R4

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && full_det && stop_on_full && full) |-> !msg_ready); // R6

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> irq_en); // R8

   AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !mem_req) |=> !mem_req); // R9

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !msg_ready); // R10

endmodule

bind msi_ring_ctrl msi_ring_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (ctrl_s.enable),
   .full_det     (ctrl_s.full_det),
   .stop_on_full (ctrl_s.stop_on_full),
   .irq_en       (ctrl_s.irq_en),
   .full         (full_s),
   .busy         (busy_s),
   .msg_ready    (msg_ready),
   .mem_req      (mem_req),
   .mem_ack      (mem_ack),
   .mem_addr     (mem_addr),
   .woff_eff     (woff_eff),
   .irq_out      (irq_out)
);

// File: tb/msi_ring_ctrl_bench.sv
module msi_ring_ctrl_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_idx = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         msg_valid = 1'b0;
   logic         msg_ready;
   logic [31:0]  msg_data = '0;
   logic         mem_req;
   logic [63:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic         mem_ack = 1'b0;
   logic         irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [31:0] ctrl_m = '0;
   logic [63:0] base_m = '0;
   logic [31:0] roff_m = '0;
   logic [31:0] woff_m = '0;

   always #5 clk = ~clk;

   msi_ring_ctrl u_msi_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_data(msg_data), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .irq_out(irq_out)
   );

   function automatic logic [31:0] mask_f(input logic [1:0] sel);
      return ((32'd1 << (15 + sel)) - 32'd1) & ~32'hF;
   endfunction
   function automatic logic [31:0] cur_mask();
      return mask_f(ctrl_m[9:8]);
   endfunction
   function automatic logic [31:0] woff_e();
      return woff_m & cur_mask();
   endfunction
   function automatic logic [31:0] roff_e();
      return roff_m & cur_mask();
   endfunction
   function automatic bit full_f();
      return ((woff_e() + 32'd16) & cur_mask()) == roff_e();
   endfunction
   function automatic bit irq_f();
      return ctrl_m[3] && (woff_e() != roff_e());
   endfunction

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] i, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = i; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      case (i)
         3'd0: ctrl_m = v & 32'h31B;
         3'd3: base_m[63:32] = v;
         3'd4: base_m[31:0] = v;
         3'd5: roff_m = v & cur_mask();
         default: ;
      endcase
   endtask

   task automatic reg_rd(input logic [2:0] i, output logic [31:0] v);
      @(negedge clk);
      reg_idx = i;
      #1 v = reg_rdata;
   endtask

   task automatic chk_offsets(input string tag);
      logic [31:0] v;
      reg_rd(3'd6, v); chk({tag, " R4 write offset"}, v, woff_e());
      reg_rd(3'd5, v); chk({tag, " R5 read offset"}, v, roff_e());
      chk({tag, " R8 irq level"}, irq_out, irq_f());
   endtask

   task automatic send_msg(input logic [31:0] d);
      bit en, stall;
      logic [31:0] eff;
      logic [63:0] a0;
      int dly;
      en = ctrl_m[0];
      stall = en && ctrl_m[1] && ctrl_m[4] && full_f();
      eff = woff_e();
      @(negedge clk);
      msg_valid = 1'b1; msg_data = d;
      #1;
      if (stall) begin
         for (int k = 0; k < 3; k++) begin
            chk("R6 ready low on full ring", msg_ready, 0);
            chk("R6 no write on full ring", mem_req, 0);
            @(negedge clk); #1;
         end
         msg_valid = 1'b0;
         return;
      end
      chk("R9 R6 ready when idle and not stalled", msg_ready, 1);
      @(negedge clk);
      msg_valid = 1'b0;
      #1;
      if (!en) begin
         for (int k = 0; k < 3; k++) begin
            chk("R9 no write while disabled", mem_req, 0);
            @(negedge clk); #1;
         end
         return;
      end
      chk("R3 request raised", mem_req, 1);
      chk("R3 record address", mem_addr, base_m + 64'(eff));
      chk("R3 data word lanes", mem_wdata[31:0], d);
      chk("R3 padding bytes zero", 64'(mem_wdata[127:32] != 96'd0), 0);
      chk("R10 ready low while writing", msg_ready, 0);
      a0 = mem_addr;
      dly = int'($urandom % 3);
      for (int k = 0; k < dly; k++) begin
         @(negedge clk); #1;
         chk("R3 request held until ack", mem_req, 1);
         chk("R3 address held until ack", mem_addr, a0);
         chk("R10 ready low while writing", msg_ready, 0);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      #1;
      chk("R3 request dropped after ack", mem_req, 0);
      woff_m = (eff + 32'd16) & cur_mask();
      chk("R8 irq after record", irq_out, irq_f());
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int guard;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R1 reset state
      chk("R1 irq low", irq_out, 0);
      chk("R1 mem_req low", mem_req, 0);
      chk("R1 ready high", msg_ready, 1);
      for (int i = 0; i < 8; i++) begin
         reg_rd(3'(i), v); chk("R1 register zero", v, 0);
      end

      // R2 register map and control field mask
      reg_wr(3'd0, 32'hFFFF_FFFF);
      reg_rd(3'd0, v); chk("R2 control keeps defined bits", v, 32'h31B);
      reg_wr(3'd0, 32'h0);
      reg_wr(3'd1, 32'hDEAD_BEEF); reg_rd(3'd1, v); chk("R2 index 1 reads zero", v, 0);
      reg_wr(3'd2, 32'h1234_5678); reg_rd(3'd2, v); chk("R2 index 2 reads zero", v, 0);
      reg_wr(3'd7, 32'hFFFF_FFFF); reg_rd(3'd7, v); chk("R2 index 7 reads zero", v, 0);
      reg_wr(3'd6, 32'h0000_0040); reg_rd(3'd6, v); chk("R2 write offset not writable", v, 0);
      reg_wr(3'd3, 32'h0000_00A5); reg_rd(3'd3, v); chk("R2 base high", v, 32'hA5);
      reg_wr(3'd4, 32'h8000_1000); reg_rd(3'd4, v); chk("R2 base low", v, 32'h8000_1000);

      // R9 disabled: dropped
      send_msg(32'h0000_1111);
      chk_offsets("R9 after drop");

      // random traffic, R3 R4 R5 R8
      reg_wr(3'd0, 32'h0000_0009);
      for (int burst = 0; burst < 6; burst++) begin
         reg_wr(3'd0, 32'h0000_0009 | ({30'd0, 2'($urandom)} << 8));
         for (int m = 0; m < 8; m++) send_msg($urandom);
         chk_offsets("R4 random burst");
         if ($urandom % 2 == 1) begin
            reg_wr(3'd5, $urandom);
            chk_offsets("R5 random read offset");
         end
      end

      // R8 catch up lowers irq
      reg_wr(3'd5, woff_e());
      chk("R8 irq low when caught up", irq_out, 0);

      // R5 mask per size
      reg_wr(3'd0, 32'h0000_0109);
      reg_wr(3'd5, 32'hFFFF_FFFF); reg_rd(3'd5, v); chk("R5 64K mask", v, 32'h0000_FFF0);
      reg_wr(3'd0, 32'h0000_0309);
      reg_wr(3'd5, 32'hFFFF_FFFF); reg_rd(3'd5, v); chk("R5 256K mask", v, 32'h0003_FFF0);
      reg_wr(3'd5, 32'h0000_0007); reg_rd(3'd5, v); chk("R5 alignment mask", v, 32'h0);

      // R6 full with stop
      reg_wr(3'd0, 32'h0000_001B);
      reg_wr(3'd5, (woff_e() + 32'd16) & cur_mask());
      chk("R6 model full", full_f(), 1);
      send_msg(32'h0000_2222);
      chk_offsets("R6 stalled");
      reg_wr(3'd5, (woff_e() + 32'd32) & cur_mask());
      send_msg(32'h0000_3333);
      chk_offsets("R6 released");
      send_msg(32'h0000_4444);
      chk_offsets("R6 stalled again");

      // R7 full without stop: overwrite
      reg_wr(3'd0, 32'h0000_000B);
      send_msg(32'h0000_5555);
      chk_offsets("R7 overwrite");
      reg_rd(3'd6, v); chk("R7 write offset reaches read offset", v, roff_e());
      chk("R7 irq low after overwrite", irq_out, 0);

      // R4 wrap on smallest ring
      reg_wr(3'd0, 32'h0000_0009);
      reg_wr(3'd5, 32'h0);
      guard = 0;
      while (woff_e() != 32'h7FF0 && guard < 2100) begin
         send_msg(32'(guard)); guard++;
      end
      send_msg(32'hCAFE_0001);
      chk_offsets("R4 wrap");
      reg_rd(3'd6, v); chk("R4 wrapped to zero", v, 0);
      send_msg(32'hCAFE_0002);
      chk_offsets("R4 after wrap");

      // R9 disable again
      reg_wr(3'd0, 32'h0000_0008);
      send_msg(32'h0000_6666);
      chk_offsets("R9 disabled");

      finish_run();
   end

endmodule